// File: doc/BRIEF.md
# Supply Warning Status and Trip-Select Register

This block is one 8-bit memory-mapped register that sits beside a supply monitor. It holds two trip-point select bits. Each drives an external analog comparator: one for the brown-out detector and one for the early-warning comparator. It also holds a sticky warning flag that software reads and then acknowledges. The warning comparator output arrives asynchronously. It passes through a synchronizer chain, and its synchronized level sets the flag. The flag ANDed with an enable input forms an interrupt request.

Three reset inputs give the cause of a reset: power-on, brown-out detect and any other cause. Every reset clears the flag and the synchronizer. Only a power-on reset returns the trip selects to the low thresholds. The other two resets leave the selects alone, so the thresholds that software chose carry through a brown-out.

The register has a single write strobe with write data and a combinational read bus. There is no address decode, because the register is the only location.

Top module: `lvw_status_reg`

## Requirements
- R1: Read data shows the warning flag in bit 7, the detector select in bit 5 and the warning select in bit 4. Bit 6 and bits 3..0 always read 0.
- R2: A warning level (warn_raw = 1) sampled at rising edge k sets the flag, which reads 1 after edge k+2 (SYNC_STAGES = 2).
- R3: Once set, the flag stays 1 after the warning level drops, until an acknowledge or a reset clears it.
- R4: A write with bit 6 = 1 clears the flag on that edge if the synchronized warning is low. If the synchronized warning is high, the set wins and the flag stays 1.
- R5: A write loads bit 5 into det_sel and bit 4 into warn_sel on the same edge. The other write bits are not stored.
- R6: A power-on reset clears det_sel, warn_sel, the flag and the synchronizer.
- R7: A brown-out or other-cause reset clears the flag and the synchronizer and keeps det_sel and warn_sel unchanged.
- R8: If the warning is still active through a reset, the flag sets again SYNC_STAGES+1 edges after the last reset edge.
- R9: irq equals the flag ANDed with irq_en.
- R10: While any reset input is high, bus writes (selects and acknowledge) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_lvd | input | 1 | Brown-out detect reset, synchronous, active high |
| rst_other | input | 1 | Reset from any other cause, synchronous, active high |
| warn_raw | input | 1 | Asynchronous warning comparator output, 1 = supply below warning trip |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| det_sel | output | 1 | Detector trip select, 1 = high threshold |
| warn_sel | output | 1 | Warning trip select, 1 = high threshold |

## Verification
The assertions check on every cycle that the reserved read bits stay zero and that the synchronized warning always sets the flag. They also check that the flag holds when nothing clears it, that a valid acknowledge clears it, and that each reset treats the selects in its own way. The count of edges from the raw comparator input to the flag can only be shown by the bench's scenarios, which compare against a cycle model. The same holds for the flag setting again after a reset while the warning stays active, and for a write made during reset being dropped.

// File: rtl/lvw_pkg.sv
package lvw_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int DSEL_BIT = 5;
  localparam int WSEL_BIT = 4;

  // Assemble the read view; unlisted bits stay zero.
  function automatic logic [REG_W-1:0] pack_status(logic flag, logic dsel, logic wsel);
    logic [REG_W-1:0] r;
    r           = '0;
    r[FLAG_BIT] = flag;
    r[DSEL_BIT] = dsel;
    r[WSEL_BIT] = wsel;
    return r;
  endfunction

  // Next value of the sticky flag: a set outranks an acknowledge.
  function automatic logic flag_next(logic cur, logic set_lvl, logic ack);
    if (set_lvl)  return 1'b1;
    else if (ack) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/lvw_sync.sv
module lvw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int MSB = STAGES - 1;
  logic [MSB:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= {chain[MSB-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[MSB];
endmodule

// File: rtl/lvw_flag.sv
module lvw_flag (
  input  logic clk,
  input  logic clr,
  input  logic set_lvl,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (clr) flag <= 1'b0;
    else     flag <= lvw_pkg::flag_next(flag, set_lvl, ack);
  end
endmodule

// File: rtl/lvw_sel.sv
module lvw_sel (
  input  logic clk,
  input  logic por,
  input  logic load,
  input  logic dsel_in,
  input  logic wsel_in,
  output logic dsel,
  output logic wsel
);
  always_ff @(posedge clk) begin
    if (por) begin
      dsel <= 1'b0;
      wsel <= 1'b0;
    end else if (load) begin
      dsel <= dsel_in;
      wsel <= wsel_in;
    end
  end
endmodule

// File: rtl/lvw_status_reg.sv
module lvw_status_reg
  import lvw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_por,
  input  logic             rst_lvd,
  input  logic             rst_other,
  input  logic             warn_raw,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             irq_en,
  output logic             irq,
  output logic             det_sel,
  output logic             warn_sel
);
  // Named internal events, visible to the bound checker
  logic rst_any;
  logic warn_sync;
  logic wr_ok;
  logic ack_req;
  logic flag;

  assign rst_any = rst_por | rst_lvd | rst_other;
  assign wr_ok   = bus_wr & ~rst_any;
  assign ack_req = wr_ok & bus_wdata[ACK_BIT];

  lvw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .clr  (rst_any),
    .din  (warn_raw),
    .dout (warn_sync)
  );

  lvw_flag u_flag (
    .clk     (clk),
    .clr     (rst_any),
    .set_lvl (warn_sync),
    .ack     (ack_req),
    .flag    (flag)
  );

  lvw_sel u_sel (
    .clk     (clk),
    .por     (rst_por),
    .load    (wr_ok),
    .dsel_in (bus_wdata[DSEL_BIT]),
    .wsel_in (bus_wdata[WSEL_BIT]),
    .dsel    (det_sel),
    .wsel    (warn_sel)
  );

  assign bus_rdata = pack_status(flag, det_sel, warn_sel);
  assign irq       = flag & irq_en;
endmodule

// File: rtl/lvw_status_chk.sv
module lvw_status_chk (
  input logic       clk,
  input logic       rst_por,
  input logic       rst_lvd,
  input logic       rst_other,
  input logic       rst_any,
  input logic       warn_sync,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_en,
  input logic       irq,
  input logic       det_sel,
  input logic       warn_sel
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst_any)
    (bus_rdata & 8'h4F) == 8'h00);

  // R2
  sync_sets_flag_chk: assert property (@(posedge clk) disable iff (rst_any)
    warn_sync |=> bus_rdata[7]);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst_any)
    (bus_rdata[7] && !(bus_wr && bus_wdata[6])) |=> bus_rdata[7]);

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst_any)
    (bus_wr && bus_wdata[6] && !warn_sync) |=> !bus_rdata[7]);

  // R6
  por_clears_chk: assert property (@(posedge clk) disable iff (!started)
    rst_por |=> (!det_sel && !warn_sel && !bus_rdata[7]));

  // R7
  warm_reset_keeps_chk: assert property (@(posedge clk) disable iff (!started || rst_por)
    (rst_lvd || rst_other) |=> (det_sel == $past(det_sel) && warn_sel == $past(warn_sel) && !bus_rdata[7]));

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!irq_en |-> !irq) and (irq |-> bus_rdata[7]));
endmodule

bind lvw_status_reg lvw_status_chk u_chk (.*);

// File: tb/lvw_status_reg_test.sv
module lvw_status_reg_test;
  logic       clk = 1'b0;
  logic       rst_por = 1'b1, rst_lvd = 1'b0, rst_other = 1'b0;
  logic       warn_raw = 1'b0, bus_wr = 1'b0, irq_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, det_sel, warn_sel;

  always #2 clk = ~clk; // 250 MHz

  lvw_status_reg uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference
  int  sync_q[$] = '{0, 0};
  bit  m_flag = 0, m_det = 0, m_warn = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit any;
    int old_sync;
    any = rst_por | rst_lvd | rst_other;
    old_sync = sync_q[$];
    if (any) begin
      sync_q = '{0, 0};
      m_flag = 0;
      if (rst_por) begin m_det = 0; m_warn = 0; end
    end else begin
      if (old_sync == 1) m_flag = 1;
      else if (bus_wr && bus_wdata[6]) m_flag = 0;
      void'(sync_q.pop_back());
      sync_q.push_front(int'(warn_raw));
      if (bus_wr) begin m_det = bus_wdata[5]; m_warn = bus_wdata[4]; end
    end
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = {m_flag, 1'b0, m_det, m_warn, 4'b0000};
    chk(bus_rdata === exp_rd, "R1 read data", bus_rdata, exp_rd);
    chk(det_sel === m_det && warn_sel === m_warn, "R5 selects",
        {det_sel, warn_sel}, {m_det, m_warn});
    chk(irq === (m_flag & irq_en), "R9 irq", irq, m_flag & irq_en);
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(bit p, bit l, bit o, bit wr, logic [7:0] wd);
    rst_por = p; rst_lvd = l; rst_other = o; bus_wr = wr; bus_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 8'h00);
    cyc(1, 0, 0, 0, 8'h00);
    chk(bus_rdata === 8'h00, "R6 reset state", bus_rdata, 0);
    idle(2);

    // R5: selects load, junk bits dropped
    cyc(0, 0, 0, 1, 8'hBF);
    chk(bus_rdata === 8'h30, "R5 write junk", bus_rdata, 8'h30);
    cyc(0, 0, 0, 1, 8'h20);
    chk({det_sel, warn_sel} === 2'b10, "R5 det only", {det_sel, warn_sel}, 2'b10);

    // R2: one-cycle pulse, flag after third edge
    warn_raw = 1;
    cyc(0, 0, 0, 0, 8'h00);
    warn_raw = 0;
    chk(bus_rdata[7] === 1'b0, "R2 edge1", bus_rdata[7], 0);
    cyc(0, 0, 0, 0, 8'h00);
    chk(bus_rdata[7] === 1'b0, "R2 edge2", bus_rdata[7], 0);
    cyc(0, 0, 0, 0, 8'h00);
    chk(bus_rdata[7] === 1'b1, "R2 edge3", bus_rdata[7], 1);
    irq_en = 1;
    idle(4);
    chk(bus_rdata[7] === 1'b1 && irq === 1'b1, "R3 sticky", {bus_rdata[7], irq}, 2'b11);

    // R4: valid acknowledge
    cyc(0, 0, 0, 1, 8'h60);
    chk(bus_rdata[7] === 1'b0 && irq === 1'b0, "R4 ack clears", {bus_rdata[7], irq}, 0);
    chk(bus_rdata === 8'h20, "R1 ack reads 0", bus_rdata, 8'h20);

    // R4: acknowledge while warning held is lost to the set
    warn_raw = 1;
    idle(3);
    cyc(0, 0, 0, 1, 8'h70);
    chk(bus_rdata[7] === 1'b1, "R4 set wins", bus_rdata[7], 1);
    idle(2);

    // R7, R8: brown-out reset with warning still active
    cyc(0, 1, 0, 0, 8'h00);
    chk(bus_rdata === 8'h30, "R7 lvd keeps selects", bus_rdata, 8'h30);
    cyc(0, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 8'h00);
    chk(bus_rdata[7] === 1'b0, "R8 not yet", bus_rdata[7], 0);
    cyc(0, 0, 0, 0, 8'h00);
    chk(bus_rdata[7] === 1'b1, "R8 flag resets", bus_rdata[7], 1);

    // R10: write during other-cause reset ignored
    cyc(0, 0, 1, 1, 8'h40);
    chk(bus_rdata === 8'h30, "R10 write in reset", bus_rdata, 8'h30);
    warn_raw = 0;
    idle(4);
    chk(bus_rdata === 8'h30, "R7 other reset", bus_rdata, 8'h30);

    // R6: power-on clears selects
    cyc(1, 0, 0, 1, 8'h30);
    chk(bus_rdata === 8'h00, "R6 por", bus_rdata, 0);
    irq_en = 0;
    warn_raw = 1;
    idle(5);
    chk(irq === 1'b0, "R9 masked", irq, 0);
    warn_raw = 0;
    cyc(0, 0, 0, 1, 8'h50);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule